// File: doc/BRIEF.md
# Low-Power Compare Timer

This block is a 16-bit up-counting timer. It counts rising edges of one of four inputs. In time-count mode the four inputs are reference clocks. In pulse-count mode they are external pulse pins. A 2-bit select field picks the input. The counter either advances on every rising edge of that input, or on every 2^(N+1)-th edge when the prescale stage is in use. N is a 4-bit divider field.

A compare register holds a match value. When the counter holds the match value and an advance arrives, three things happen:
- the counter wraps to zero,
- a sticky match flag is set,
- a trigger output goes high and stays high until the next advance.

With a match value of zero, every advance is a match, so the trigger stays high until the timer is disabled. The configuration is locked while the timer runs. A compare update is taken while running only once the flag shows a match.

All logic runs on one system clock. The timer inputs are sampled as levels on that clock, and their rising edges are detected. Software reaches the block through a word-wide register port. Writes take effect at a clock edge. Reads are combinational from the address.

Top module: `lpcmp_timer`

## Requirements
- R1: After reset the enable, mode, select, bypass, divider, compare, counter and flag are all zero, all four addresses read 0, and `trig_o` is low.
- R2: The select field, bits [1:0] at address 1, picks input 0..3. Rising edges on any other input do not advance the counter.
- R3: With the bypass bit (address 1, bit 2) set, each rising edge of the selected input advances the counter by one.
- R4: With the bypass bit clear and divider field N (address 1, bits [6:3]), the counter advances once for every 2^(N+1) rising edges of the selected input, counted from the moment the timer is enabled.
- R5: Mode bit (address 0, bit 1) equal to 0 takes edges from `ref_clk_i`, and equal to 1 takes them from `pulse_i`. Edges on the other vector are ignored.
- R6: While the enable bit (address 0, bit 0) is 1, writes to address 1 and to the mode bit are ignored.
- R7: The compare value sits at address 2, bits [15:0]. Bits [31:16] read as zero and ignore writes.
- R8: An advance that arrives while the counter equals the compare value sets the flag (address 0, bit 7) and returns the counter to 0. Any other advance adds one to the counter. The counter is read at address 3.
- R9: `trig_o` rises on the match advance and falls on the next advance that is not a match.
- R10: With a compare value of 0, `trig_o` stays high from the first advance until the timer is disabled.
- R11: While enabled, a write to address 2 is taken only when the flag is set. While disabled, it is always taken.
- R12: Clearing the enable bit zeroes the counter, the flag and `trig_o`. Writing 1 to address 0, bit 7 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk_i | input | 4 | Reference clock inputs for time-count mode |
| pulse_i | input | 4 | Pulse inputs for pulse-count mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 prescale, 2 compare, 3 counter |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| trig_o | output | 1 | Hardware trigger output |

## Verification
The bound checker watches several rules on every clock:
- the locked prescale configuration and the guarded compare value stay unchanged,
- a match advance always leaves the flag set, the counter at zero and the trigger high,
- the trigger only moves on an advance or a disable,
- a disabled timer always has a clear counter, flag and trigger.

Other behaviour needs a reference model, and only the bench's scenarios can show it. This covers the exact advance rate for each divider setting, which input and mode actually feed the counter, the periodic wrap and the clearing of the flag by writing 1.

// File: rtl/lpct_pkg.sv
package lpct_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd3;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_MODE_BIT  = 1;
  localparam int CTRL_FLAG_BIT  = 7;
endpackage

// File: rtl/lpct_src_sel.sv
module lpct_src_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ref_i,
  input  logic [N_SRC-1:0] pulse_i,
  input  logic             pulse_mode,
  input  logic [SEL_W-1:0] sel,
  output logic             event_o
);
  logic src;
  logic prev_q;

  always_comb begin
    src = pulse_mode ? pulse_i[sel] : ref_i[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= src;
  end

  assign event_o = src & ~prev_q;
endmodule

// File: rtl/lpct_prescale.sv
module lpct_prescale #(
  parameter int PSC_W = 4,
  localparam int DIV_W = 1 << PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             event_i,
  input  logic             bypass,
  input  logic [PSC_W-1:0] div_n,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] ones;
  logic [DIV_W-1:0] mask;

  always_comb begin
    ones = '1;
    mask = ones >> (PSC_W'(DIV_W - 1) - div_n);
    div_d = div_q;
    if (!en)          div_d = '0;
    else if (event_i) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = en & event_i & (bypass | ((div_q & mask) == mask));
endmodule

// File: rtl/lpct_match.sv
module lpct_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             trig_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             trig_q, trig_d;
  logic             hit;

  always_comb begin
    hit    = tick && (cnt_q == cmp);
    cnt_d  = cnt_q;
    flag_d = flag_q;
    trig_d = trig_q;
    if (!en) begin
      cnt_d  = '0;
      flag_d = 1'b0;
      trig_d = 1'b0;
    end else begin
      if (flag_clr) flag_d = 1'b0;
      if (hit) begin
        cnt_d  = '0;
        flag_d = 1'b1;
        trig_d = 1'b1;
      end else if (tick) begin
        cnt_d  = cnt_q + 1'b1;
        trig_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      trig_q <= trig_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/lpcmp_timer.sv
module lpcmp_timer
  import lpct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_SRC  = 4,
  parameter int PSC_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  ref_clk_i,
  input  logic [N_SRC-1:0]  pulse_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              trig_o
);
  localparam int SEL_W   = $clog2(N_SRC);
  localparam int BYP_BIT = SEL_W;
  localparam int DIV_LSB = SEL_W + 1;

  logic [1:0]       rst_ff;
  logic             rst_q_n;
  logic             en_q, en_d;
  logic             pmode_q, pmode_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             byp_q, byp_d;
  logic [PSC_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             flag_clr;
  logic             src_event;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             flag;
  logic             unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_q_n = rst_ff[1];

  always_comb begin
    en_d     = en_q;
    pmode_d  = pmode_q;
    sel_d    = sel_q;
    byp_d    = byp_q;
    div_d    = div_q;
    cmp_d    = cmp_q;
    flag_clr = 1'b0;
    if (wr_en_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          en_d     = wdata_i[CTRL_EN_BIT];
          flag_clr = wdata_i[CTRL_FLAG_BIT];
          if (!en_q) pmode_d = wdata_i[CTRL_MODE_BIT];
        end
        ADDR_PSC: begin
          if (!en_q) begin
            sel_d = wdata_i[SEL_W-1:0];
            byp_d = wdata_i[BYP_BIT];
            div_d = wdata_i[DIV_LSB +: PSC_W];
          end
        end
        ADDR_CMP: begin
          if (!en_q || flag) cmp_d = wdata_i[CNT_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      en_q    <= 1'b0;
      pmode_q <= 1'b0;
      sel_q   <= '0;
      byp_q   <= 1'b0;
      div_q   <= '0;
      cmp_q   <= '0;
    end else begin
      en_q    <= en_d;
      pmode_q <= pmode_d;
      sel_q   <= sel_d;
      byp_q   <= byp_d;
      div_q   <= div_d;
      cmp_q   <= cmp_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_MODE_BIT] = pmode_q;
        rdata_o[CTRL_FLAG_BIT] = flag;
      end
      ADDR_PSC: begin
        rdata_o[SEL_W-1:0]        = sel_q;
        rdata_o[BYP_BIT]          = byp_q;
        rdata_o[DIV_LSB +: PSC_W] = div_q;
      end
      ADDR_CMP: rdata_o[CNT_W-1:0] = cmp_q;
      default:  rdata_o[CNT_W-1:0] = cnt;
    endcase
  end

  assign unused_wdata = ^wdata_i;

  lpct_src_sel #(.N_SRC(N_SRC)) u_src (
    .clk(clk), .rst_n(rst_q_n), .ref_i(ref_clk_i), .pulse_i(pulse_i),
    .pulse_mode(pmode_q), .sel(sel_q), .event_o(src_event)
  );

  lpct_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_q_n), .en(en_q), .event_i(src_event),
    .bypass(byp_q), .div_n(div_q), .tick_o(tick)
  );

  lpct_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_q_n), .en(en_q), .tick(tick), .cmp(cmp_q),
    .flag_clr(flag_clr), .cnt_o(cnt), .flag_o(flag), .trig_o(trig_o)
  );
endmodule

// File: rtl/lpcmp_timer_chk.sv
module lpcmp_timer_chk #(
  parameter int CNT_W = 16,
  parameter int CFG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             flag,
  input logic             trig,
  input logic [CFG_W-1:0] psc_cfg,
  input logic             wr_ctrl
);
  // R6: prescale configuration frozen while running
  assert_psc_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(psc_cfg));

  // R11: compare value only moves when stopped or after a match
  assert_cmp_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !flag) |=> $stable(cmp));

  // R8: match advance sets flag, wraps counter, raises trigger
  assert_match_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && (cnt == cmp) && !wr_ctrl) |=> (flag && cnt == '0 && trig));

  // R9: trigger moves only on an advance or when disabled
  assert_trig_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> ($stable(trig) || !en));

  // R10: zero compare keeps trigger high while running
  assert_trig_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmp == '0 && trig && !wr_ctrl) |=> trig);

  // R12: a stopped timer holds counter, flag and trigger clear
  assert_disabled_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !flag && !trig));
endmodule

bind lpcmp_timer lpcmp_timer_chk #(.CNT_W(CNT_W), .CFG_W(SEL_W + 1 + PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .en(en_q), .tick(tick), .cnt(cnt), .cmp(cmp_q),
  .flag(flag), .trig(trig_o), .psc_cfg({sel_q, byp_q, div_q}),
  .wr_ctrl(wr_en_i && addr_i == lpct_pkg::ADDR_CTRL)
);

// File: tb/lpcmp_timer_bench.sv
module lpcmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ref_clk_i, pulse_i;
  logic        wr_en_i;
  logic [1:0]  addr_i;
  logic [31:0] wdata_i, rdata_o;
  logic        trig_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit      m_en, m_mode, m_byp, m_flag, m_trig;
  int      m_sel, m_div, m_cmp, m_cnt, m_edges;

  always #10 clk = ~clk;

  lpcmp_timer u_lpcmp_timer (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk_i), .pulse_i(pulse_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .trig_o(trig_o)
  );

  function automatic bit is_tick(input int edges, input bit byp, input int div);
    int period;
    period = 1 << (div + 1);
    return byp || ((edges % period) == 0);
  endfunction

  function automatic int next_cnt(input int cnt, input int cmp);
    return (cnt == cmp) ? 0 : cnt + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    case (a)
      2'd0: begin
        if (!m_en) m_mode = d[1];
        if (d[7]) m_flag = 0;
        m_en = d[0];
        if (!m_en) begin m_cnt = 0; m_flag = 0; m_trig = 0; m_edges = 0; end
      end
      2'd1: if (!m_en) begin m_sel = d[1:0]; m_byp = d[2]; m_div = d[6:3]; end
      2'd2: if (!m_en || m_flag) m_cmp = d[15:0];
      default: ;
    endcase
  endtask

  // kind 0 = reference clock, 1 = pulse pin
  task automatic pulse(input bit kind, input int idx);
    @(negedge clk);
    if (kind) pulse_i[idx] = 1'b1; else ref_clk_i[idx] = 1'b1;
    @(negedge clk);
    if (kind) pulse_i[idx] = 1'b0; else ref_clk_i[idx] = 1'b0;
    if (m_en && kind == m_mode && idx == m_sel) begin
      m_edges++;
      if (is_tick(m_edges, m_byp, m_div)) begin
        if (m_cnt == m_cmp) begin m_flag = 1; m_trig = 1; end
        else m_trig = 0;
        m_cnt = next_cnt(m_cnt, m_cmp);
      end
    end
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    rd(2'd3, d);
    chk(req, d, 32'(m_cnt));
    chk(req, 32'(trig_o), 32'(m_trig));
    rd(2'd0, d);
    chk(req, 32'(d[7]), 32'(m_flag));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'h1A2B);
    rst_n = 1'b0; ref_clk_i = '0; pulse_i = '0; wr_en_i = 0; addr_i = 0; wdata_i = 0;
    m_en = 0; m_mode = 0; m_byp = 0; m_flag = 0; m_trig = 0;
    m_sel = 0; m_div = 0; m_cmp = 0; m_cnt = 0; m_edges = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1", d, 32'h0);
    end
    chk("R1", 32'(trig_o), 32'h0);

    // R7: upper compare bits
    wr(2'd2, 32'hABCD_1234);
    rd(2'd2, d);
    chk("R7", d, 32'h0000_1234);

    // R6: locked configuration
    wr(2'd1, 32'h0000_0005);          // sel 1, bypass
    wr(2'd2, 32'h0000_0002);
    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'h0000_007A);
    rd(2'd1, d);
    chk("R6", d, 32'h0000_0005);
    wr(2'd0, 32'h0000_0003);
    rd(2'd0, d);
    chk("R6", 32'(d[1]), 32'h0);

    // R2/R5: wrong input and wrong vector ignored
    pulse(0, 0); check_state("R2");
    pulse(1, 1); check_state("R5");
    // R3/R8/R9: three edges reach the match
    pulse(0, 1); pulse(0, 1); check_state("R3");
    pulse(0, 1); check_state("R8");
    chk("R9", 32'(trig_o), 32'h1);
    // R11: write accepted after match
    wr(2'd2, 32'h0000_0004);
    rd(2'd2, d);
    chk("R11", d, 32'h4);
    pulse(0, 1); check_state("R9");
    chk("R9", 32'(trig_o), 32'h0);
    // R12: write-1 clears flag; R11: then compare locked
    wr(2'd0, 32'h0000_0081);
    check_state("R12");
    wr(2'd2, 32'h0000_0009);
    rd(2'd2, d);
    chk("R11", d, 32'h4);

    // R10: zero compare holds trigger
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h1);
    for (int i = 0; i < 4; i++) begin
      pulse(0, 1);
      chk("R10", 32'(trig_o), 32'h1);
    end
    wr(2'd0, 32'h0);
    check_state("R12");

    // R4: divide by 4 in pulse mode
    wr(2'd1, 32'h0000_000A);          // sel 2, div N=1
    wr(2'd2, 32'h0000_00FF);
    wr(2'd0, 32'h0000_0003);
    for (int i = 0; i < 9; i++) pulse(1, 2);
    check_state("R4");
    chk("R4", 32'(m_cnt), 32'h2);

    // constrained random mix
    for (int cfg = 0; cfg < 40; cfg++) begin
      wr(2'd0, 32'h0);
      wr(2'd1, {25'd0, 4'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                2'($urandom_range(0, 3))});
      wr(2'd2, 32'($urandom_range(0, 6)));
      wr(2'd0, {30'd0, 1'($urandom_range(0, 1)), 1'b1});
      for (int op = 0; op < 25; op++) begin
        int r;
        bit k;
        int idx;
        r = $urandom_range(0, 19);
        if (r == 0) begin
          wr(2'd2, 32'($urandom_range(0, 6)));
          check_state("R11");
        end else if (r == 1) begin
          wr(2'd0, 32'h81);
          check_state("R12");
        end else begin
          k = 1'($urandom_range(0, 3) != 0 ? m_mode : !m_mode);
          idx = ($urandom_range(0, 2) != 0) ? m_sel : int'($urandom_range(0, 3));
          pulse(k, idx);
          if (k != m_mode)       check_state("R5");
          else if (idx != m_sel) check_state("R2");
          else if (m_byp)        check_state("R3");
          else                   check_state("R4");
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule